// File: doc/BRIEF.md
# Dual-Image Reconfiguration Sequencer

This block controls remote reconfiguration between two bitstreams held in a serial configuration flash. One of them is a factory image at address zero, which is always loaded at power-up. The other is an application image. The block tracks which image is running. It turns push-button presses, or an addressed request from the host, into a single-cycle reconfiguration trigger, and presents the target address alongside that trigger. It then waits for the configuration logic to report either success or an error.

The sequencer enforces the ordering rules of the update scheme:

- From the factory image, button 1 loads the application image at its fixed base address.
- From the application image, button 0 returns to the factory image.
- An application image can never hand over directly to another application image. Such a request is converted into a forced factory load.
- A configuration error always falls back to the factory image.

Four LEDs show which image is running. One is held steady and one blinks for each image. A small read port exposes the active image, the cause of the last reconfiguration and the current boot address. The logic is intended for a clock of 40 MHz or lower.

Top module: `dual_image_reconfig`

## Requirements
- R1: After reset the factory image is active: `active_app`=0, `boot_addr`=0, `busy`=0, `trig`=0, and the cause field reads 00 (power-up).
- R2: While the factory image is active, one press of `btn[1]` produces exactly one trigger, however long the button is held. The trigger comes with `cfg_addr`=APP_BASE (default 0x00320000, unshifted). The trigger is high at the fourth falling edge after the press is applied, because the press passes a two-stage synchroniser and an edge detector.
- R3: `trig` lasts exactly one cycle. It appears one cycle after a request is accepted, and `busy` rises in the cycle of acceptance. For the host request port, this places `trig` at the second falling edge after `req_stb` is applied.
- R4: A `cfg_done` pulse while loading makes the target the active image. `boot_addr` takes the target address, `active_app` becomes 1 exactly when the target is not address 0, and the cause becomes 01 (user request) for accepted user requests.
- R5: While the application image is active, `btn[0]` triggers a load of address 0. `btn[0]` while the factory image is active, and `btn[1]` while the application image is active, produce no trigger.
- R6: While the application image is active, a host request for any non-zero address triggers a load of address 0 instead. After completion the cause reads 11 (refused request).
- R7: A `cfg_err` pulse while loading issues a new trigger to address 0 at the second falling edge. The cause becomes 10 (configuration error), and the factory image becomes active at `cfg_done`.
- R8: A host request whose address is not aligned to a 2^SUB_LOG2-byte subsector (default 4 KiB) is rejected: no trigger, `busy` stays 0, and the state is unchanged.
- R9: While `busy` is 1, button presses and host requests are ignored: no further trigger is issued and the load in progress completes normally.
- R10: LEDs are assigned as follows. With the factory image active, `led[2]`=1, `led[3]`=0, `led[1]`=0 and `led[0]` toggles every BLINK_HALF cycles. With the application image active, `led[3]`=1, `led[2]`=0, `led[0]`=0 and `led[1]` blinks.
- R11: With `rd_sel`=0, `rd_data` bit 0 is the active image (1 = application) and bits 2:1 are the cause. With `rd_sel`=1, `rd_data` is `boot_addr`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, 40 MHz or lower |
| rst_n | input | 1 | Asynchronous active-low reset |
| btn | input | 2 | Raw push buttons, active high; bit 0 selects factory, bit 1 selects application |
| req_stb | input | 1 | Host reconfiguration request strobe |
| req_addr | input | ADDR_W | Target flash address for a host request |
| cfg_done | input | 1 | Configuration completed successfully |
| cfg_err | input | 1 | Configuration failed |
| rd_sel | input | 1 | Read select: 0 status, 1 boot address |
| trig | output | 1 | Single-cycle reconfiguration trigger |
| busy | output | 1 | Request accepted and load not yet finished |
| cfg_addr | output | ADDR_W | Address to be loaded, valid with `trig` |
| active_app | output | 1 | 1 when the application image is active |
| boot_addr | output | ADDR_W | Start address of the active image |
| led | output | 4 | Image indicator LEDs |
| rd_data | output | ADDR_W | Read data |

## Verification
The assertions check the following on every cycle:

- `trig` is single-cycle and is always preceded by `busy`.
- Every triggered address is subsector-aligned.
- Every trigger issued while the application image runs targets address 0.
- The boot address is held while a load is in progress.
- The steady LEDs follow the active image.

Only the directed scenarios can show the exact trigger latency through the synchroniser and the one-trigger-per-press behaviour. The same holds for the cause codes recorded for user, refused and error reconfigurations, the rejection of unaligned addresses, and the blink period.

// File: rtl/dual_image_reconfig.sv
module dual_image_reconfig #(
  parameter int          ADDR_W     = 32,
  parameter logic [31:0] APP_BASE   = 32'h0032_0000,
  parameter int          SUB_LOG2   = 12,
  parameter int          BLINK_HALF = 20_000_000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        btn,
  input  logic              req_stb,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic              cfg_done,
  input  logic              cfg_err,
  input  logic              rd_sel,
  output logic              trig,
  output logic              busy,
  output logic [ADDR_W-1:0] cfg_addr,
  output logic              active_app,
  output logic [ADDR_W-1:0] boot_addr,
  output logic [3:0]        led,
  output logic [ADDR_W-1:0] rd_data
);
  localparam int CNT_W = $clog2(BLINK_HALF + 1);
  localparam logic [ADDR_W-1:0] FACT = '0;
  localparam logic [ADDR_W-1:0] APP  = APP_BASE[ADDR_W-1:0];
  localparam logic [1:0] C_PWR = 2'b00, C_USER = 2'b01, C_ERR = 2'b10, C_REF = 2'b11;

  typedef enum logic [1:0] {ST_IDLE, ST_ARM, ST_LOAD} st_t;
  st_t st;

  logic [1:0] s1, s2, s3;
  logic [1:0] rise;
  logic [1:0] cause;
  logic       aligned;
  logic              acc;
  logic [ADDR_W-1:0] acc_addr;
  logic [1:0]        acc_cause;
  logic [CNT_W-1:0]  cnt;
  logic              blink;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) {s1, s2, s3} <= '0;
    else begin
      s1 <= btn;
      s2 <= s1;
      s3 <= s2;
    end

  assign rise    = s2 & ~s3;
  assign busy    = (st != ST_IDLE);
  assign aligned = (req_addr[SUB_LOG2-1:0] == '0);

  always_comb begin
    acc       = 1'b0;
    acc_addr  = FACT;
    acc_cause = C_USER;
    if (st == ST_IDLE) begin
      if (!active_app && rise[1]) begin
        acc      = 1'b1;
        acc_addr = APP;
      end else if (active_app && rise[0]) begin
        acc = 1'b1;
      end else if (req_stb && aligned) begin
        acc = 1'b1;
        if (req_addr != FACT) begin
          if (active_app) acc_cause = C_REF;
          else            acc_addr  = req_addr;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      st         <= ST_IDLE;
      trig       <= 1'b0;
      cfg_addr   <= FACT;
      active_app <= 1'b0;
      boot_addr  <= FACT;
      cause      <= C_PWR;
    end else begin
      trig <= (st == ST_ARM);
      case (st)
        ST_IDLE:
          if (acc) begin
            st       <= ST_ARM;
            cfg_addr <= acc_addr;
            cause    <= acc_cause;
          end
        ST_ARM: st <= ST_LOAD;
        ST_LOAD:
          if (cfg_err) begin
            st       <= ST_ARM;
            cfg_addr <= FACT;
            cause    <= C_ERR;
          end else if (cfg_done) begin
            st         <= ST_IDLE;
            active_app <= (cfg_addr != FACT);
            boot_addr  <= cfg_addr;
          end
        default: st <= ST_IDLE;
      endcase
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      cnt   <= '0;
      blink <= 1'b0;
    end else if (cnt == CNT_W'(BLINK_HALF - 1)) begin
      cnt   <= '0;
      blink <= ~blink;
    end else begin
      cnt <= cnt + 1'b1;
    end

  assign led = active_app ? {1'b1, 1'b0, blink, 1'b0} : {1'b0, 1'b1, 1'b0, blink};

  assign rd_data = rd_sel ? boot_addr : {{(ADDR_W-3){1'b0}}, cause, active_app};
endmodule

// File: rtl/dual_image_reconfig_chk.sv
module dual_image_reconfig_chk #(
  parameter int ADDR_W   = 32,
  parameter int SUB_LOG2 = 12
) (
  input logic              clk,
  input logic              rst_n,
  input logic              trig,
  input logic              busy,
  input logic [ADDR_W-1:0] cfg_addr,
  input logic              active_app,
  input logic [ADDR_W-1:0] boot_addr,
  input logic [3:0]        led
);
  AST_TRIG_SINGLE: assert property (@(posedge clk) disable iff (!rst_n) trig |=> !trig); // R3
  AST_TRIG_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n) trig |-> $past(busy)); // R3
  AST_TRIG_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n) trig |-> (cfg_addr[SUB_LOG2-1:0] == '0)); // R8
  AST_APP_TO_FACTORY: assert property (@(posedge clk) disable iff (!rst_n) (trig && active_app) |-> (cfg_addr == '0)); // R6
  AST_BOOT_HELD: assert property (@(posedge clk) disable iff (!rst_n) (busy && $past(busy)) |-> $stable(boot_addr)); // R9
  AST_LED_STEADY: assert property (@(posedge clk) disable iff (!rst_n) (led[3] == active_app) && (led[2] == !active_app)); // R10
  AST_LED_BLINK_OWNER: assert property (@(posedge clk) disable iff (!rst_n) active_app ? !led[0] : !led[1]); // R10
endmodule

bind dual_image_reconfig dual_image_reconfig_chk #(.ADDR_W(ADDR_W), .SUB_LOG2(SUB_LOG2)) u_chk (
  .clk(clk), .rst_n(rst_n), .trig(trig), .busy(busy), .cfg_addr(cfg_addr),
  .active_app(active_app), .boot_addr(boot_addr), .led(led)
);

// File: tb/tb_dual_image_reconfig.sv
module tb_dual_image_reconfig;
  localparam int HALF = 8;
  logic        clk = 1'b0, rst_n = 1'b0;
  logic [1:0]  btn = '0;
  logic        req_stb = 1'b0, cfg_done = 1'b0, cfg_err = 1'b0, rd_sel = 1'b0;
  logic [31:0] req_addr = '0;
  logic        trig, busy, active_app;
  logic [31:0] cfg_addr, boot_addr, rd_data;
  logic [3:0]  led;
  int checks = 0, errors = 0;

  always #4 clk = ~clk;

  dual_image_reconfig #(.BLINK_HALF(HALF)) dut (
    .clk(clk), .rst_n(rst_n), .btn(btn), .req_stb(req_stb), .req_addr(req_addr),
    .cfg_done(cfg_done), .cfg_err(cfg_err), .rd_sel(rd_sel), .trig(trig), .busy(busy),
    .cfg_addr(cfg_addr), .active_app(active_app), .boot_addr(boot_addr), .led(led),
    .rd_data(rd_data));

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic wait_trig(input int lim, output int n);
    n = 0;
    for (int i = 1; i <= lim; i++) begin
      @(negedge clk);
      if (i == 1) begin req_stb = 1'b0; cfg_err = 1'b0; end
      if (trig) begin n = i; break; end
    end
  endtask

  task automatic press(input int b, output int n, output int extra);
    @(negedge clk);
    btn[b] = 1'b1;
    wait_trig(12, n);
    extra = 0;
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      if (trig) extra++;
    end
    btn[b] = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  task automatic send_req(input logic [31:0] a, output int n);
    @(negedge clk);
    req_stb = 1'b1;
    req_addr = a;
    wait_trig(8, n);
  endtask

  task automatic finish_load();
    @(negedge clk);
    cfg_done = 1'b1;
    @(negedge clk);
    cfg_done = 1'b0;
  endtask

  task automatic read_status(output logic [31:0] v);
    rd_sel = 1'b0; #1 v = rd_data;
  endtask

  task automatic t_reset();
    logic [31:0] v;
    chk(active_app == 1'b0 && busy == 1'b0 && trig == 1'b0, "R1 idle factory", {active_app, busy, trig}, 0);
    chk(boot_addr == 0, "R1 boot_addr", boot_addr, 0);
    read_status(v);
    chk(v == 0, "R1 R11 cause power-up", v, 0);
    chk(led == 4'b0100, "R10 reset leds", led, 4'b0100);
  endtask

  task automatic t_btn_to_app();
    int n, x;
    logic [31:0] v;
    press(1, n, x);
    chk(n == 4, "R2 btn1 trigger latency", n, 4);
    chk(cfg_addr == 32'h0032_0000, "R2 app address unshifted", cfg_addr, 32'h0032_0000);
    chk(x == 0, "R2 R3 single trigger per held press", x, 0);
    chk(busy == 1'b1, "R3 busy during load", busy, 1);
    finish_load();
    chk(active_app == 1'b1 && boot_addr == 32'h0032_0000, "R4 app committed", boot_addr, 32'h0032_0000);
    read_status(v);
    chk(v == 32'h3, "R4 R11 status user app", v, 32'h3);
    rd_sel = 1'b1; #1;
    chk(rd_data == 32'h0032_0000, "R11 boot readback", rd_data, 32'h0032_0000);
    rd_sel = 1'b0;
    chk(led[3] == 1'b1 && led[2] == 1'b0 && led[0] == 1'b0, "R10 app leds", led, 4'b1000);
  endtask

  task automatic t_wrong_button(input int b);
    int n, x;
    press(b, n, x);
    chk(n == 0 && busy == 1'b0, "R5 wrong button ignored", n, 0);
  endtask

  task automatic t_refused();
    int n;
    logic [31:0] v;
    send_req(32'h0040_0000, n);
    chk(n == 2, "R6 refused request trigger", n, 2);
    chk(cfg_addr == 0, "R6 forced factory address", cfg_addr, 0);
    finish_load();
    read_status(v);
    chk(v == 32'h6, "R6 cause refused, factory", v, 32'h6);
  endtask

  task automatic t_unaligned();
    int n;
    logic [31:0] v;
    send_req(32'h0032_0800, n);
    chk(n == 0 && busy == 1'b0, "R8 unaligned rejected", n, 0);
    read_status(v);
    chk(v == 32'h6 && boot_addr == 0, "R8 state unchanged", v, 32'h6);
  endtask

  task automatic t_host_app();
    int n;
    send_req(32'h0040_0000, n);
    chk(n == 2, "R3 host trigger one cycle after accept", n, 2);
    chk(cfg_addr == 32'h0040_0000, "R3 host address", cfg_addr, 32'h0040_0000);
    @(negedge clk);
    chk(trig == 1'b0, "R3 trigger single cycle", trig, 0);
    finish_load();
    chk(boot_addr == 32'h0040_0000 && active_app, "R4 host app committed", boot_addr, 32'h0040_0000);
  endtask

  task automatic t_btn_to_factory();
    int n, x;
    press(0, n, x);
    chk(n == 4 && cfg_addr == 0, "R5 btn0 returns to factory", cfg_addr, 0);
    finish_load();
    chk(!active_app && boot_addr == 0, "R5 factory committed", boot_addr, 0);
  endtask

  task automatic t_blink();
    int tog = 0;
    logic prev;
    logic bad = 1'b0;
    @(negedge clk);
    prev = led[0];
    for (int i = 0; i < 4 * HALF; i++) begin
      @(negedge clk);
      if (led[0] != prev) tog++;
      if (led[1] || led[3] || !led[2]) bad = 1'b1;
      prev = led[0];
    end
    chk(tog == 4, "R10 factory blink toggles", tog, 4);
    chk(!bad, "R10 factory steady leds", led, 4'b0100);
  endtask

  task automatic t_busy_err();
    int n, x, extra;
    logic [31:0] v;
    press(1, n, x);
    chk(n == 4, "R2 second app request", n, 4);
    extra = 0;
    @(negedge clk);
    btn[0] = 1'b1; req_stb = 1'b1; req_addr = 0;
    @(negedge clk);
    req_stb = 1'b0;
    if (trig) extra++;
    for (int i = 0; i < 10; i++) begin
      @(negedge clk);
      if (trig) extra++;
    end
    btn[0] = 1'b0;
    repeat (4) @(negedge clk);
    chk(extra == 0 && busy == 1'b1, "R9 inputs ignored while busy", extra, 0);
    @(negedge clk);
    cfg_err = 1'b1;
    wait_trig(8, n);
    chk(n == 2 && cfg_addr == 0, "R7 error retriggers factory", cfg_addr, 0);
    finish_load();
    read_status(v);
    chk(v == 32'h4 && boot_addr == 0, "R7 cause error, factory active", v, 32'h4);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_btn_to_app();
    t_wrong_button(1);
    t_refused();
    t_unaligned();
    t_host_app();
    t_btn_to_factory();
    t_wrong_button(0);
    t_blink();
    t_busy_err();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule